// File: doc/BRIEF.md
# Interleaved Four-Bank Block-Fill Memory

This block is a main-memory model and controller. It serves cache-line refills from a set of independent banks that are interleaved by word. Each word address is split in two. The low bits pick a bank and the upper bits pick a row inside that bank, so neighbouring words live in neighbouring banks.

For a block read, the controller spends one cycle sending the row to every bank. All banks then run their access delay side by side. The words then come back over a single one-word response bus, one word per cycle, with the last one flagged. With four banks and a six-cycle access, the whole line arrives in eleven cycles. A memory that serves one word at a time would need thirty-two cycles for the same line.

Single-word reads and single-word writes go to one bank only. A simple ready/valid handshake keeps a new request out until the current one has finished.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a transfer, `req_ready` is 1 and `rsp_valid` and `wr_done` are 0 until a new request is accepted.
- R2: Word address `a` is held in bank `a % 4` at row `a / 4`. A word written at `a` is returned whenever `a` is read, alone or as part of its block.
- R3: `req_op` = 2'b00 is a block read. If it is accepted at clock edge E, its four words appear after edges E+8, E+9, E+10 and E+11, with `rsp_valid` high in each of those cycles and low again after E+12.
- R4: A block read returns the words in ascending bank order 0, 1, 2, 3. `rsp_last` is 1 only on the fourth word.
- R5: For a block read, the two low address bits are ignored. The block returned is the aligned group that contains the address.
- R6: `req_op` = 2'b01 is a single-word read. If it is accepted at edge E, one word appears after edge E+8 with `rsp_valid` and `rsp_last` both 1.
- R7: `req_op` = 2'b10 (or 2'b11) is a single-word write. If it is accepted at edge E, `wr_done` pulses for exactly the one cycle after edge E+7. Only the addressed word changes; the other words of its block keep their values.
- R8: `req_ready` is 0 from the cycle after acceptance until the transaction ends. A request presented while busy is ignored: it writes nothing and produces no response.
- R9: `req_ready` returns to 1 in the same cycle as the final word or the `wr_done` pulse, so a request presented then is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is accepted when it is high together with `req_valid` |
| req_op | input | 2 | 00 block read, 01 word read, 1x word write |
| req_addr | input | ADDR_W (8) | Word address |
| req_wdata | input | DATA_W (32) | Data for a write |
| rsp_valid | output | 1 | Response word valid |
| rsp_last | output | 1 | Final word of the response |
| rsp_data | output | DATA_W (32) | Response word |
| wr_done | output | 1 | One-cycle pulse when a write has finished |

## Verification
The assertions assume that `req_op` and `req_addr` are stable in the cycle where `req_valid` meets `req_ready`. They also assume that every word is written before it is read, because bank contents are not reset. The bench changes its inputs only on falling clock edges and samples outputs there too. It fills every address it later reads, before it reads it. Requests raised while the controller is busy are deliberate, and their only purpose is to show that they are dropped.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam logic [1:0] OP_BLOCK = 2'b00;
  localparam logic [1:0] OP_READ  = 2'b01;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ADDR,
    S_WAIT,
    S_XFER
  } seq_state_t;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 6,
  parameter int LAT    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  timer;
  logic [ROW_W-1:0]  row_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic              fire;

  assign fire  = (timer == CNT_W'(1));
  assign ready = (timer == '0);

  // access timer: loaded on start, the array is touched on its last count
  always_ff @(posedge clk) begin
    if (rst) timer <= '0;
    else if (start) timer <= CNT_W'(LAT);
    else if (!ready) timer <= timer - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (start) begin
      row_q <= row;
      we_q  <= wr_en;
      wd_q  <= wdata;
    end
  end

  // single-port array, registered read
  always_ff @(posedge clk) begin
    if (fire) begin
      if (we_q) mem[row_q] <= wd_q;
      else      rdata      <= mem[row_q];
    end
  end
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LAT    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  output logic                     rsp_valid,
  output logic                     rsp_last,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     wr_done,
  output logic [NB-1:0]            bank_start,
  output logic                     bank_we,
  output logic [ADDR_W-$clog2(NB)-1:0] bank_row,
  output logic [DATA_W-1:0]        bank_wdata,
  input  logic [NB-1:0][DATA_W-1:0] bank_rdata
);
  localparam int SEL_W = $clog2(NB);
  localparam int CNT_W = $clog2(LAT + 1);

  seq_state_t        state;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  cnt;
  logic [SEL_W-1:0]  idx;
  logic              is_blk;
  logic              accept;

  assign is_blk    = (op_q == OP_BLOCK);
  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;

  assign bank_we    = op_q[1];
  assign bank_row   = addr_q[ADDR_W-1:SEL_W];
  assign bank_wdata = wdata_q;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_start
      assign bank_start[b] = (state == S_ADDR) &&
                             (is_blk || (addr_q[SEL_W-1:0] == SEL_W'(b)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_BLOCK;
      addr_q    <= '0;
      wdata_q   <= '0;
      cnt       <= '0;
      idx       <= '0;
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      rsp_data  <= '0;
      wr_done   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      wr_done   <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          op_q    <= req_op;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          state   <= S_ADDR;
        end
        S_ADDR: begin
          cnt   <= CNT_W'(LAT);
          state <= S_WAIT;
        end
        S_WAIT: begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) begin
            if (op_q[1]) begin
              wr_done <= 1'b1;
              state   <= S_IDLE;
            end else begin
              idx   <= is_blk ? '0 : addr_q[SEL_W-1:0];
              state <= S_XFER;
            end
          end
        end
        S_XFER: begin
          rsp_valid <= 1'b1;
          rsp_data  <= bank_rdata[idx];
          if (!is_blk || idx == SEL_W'(NB - 1)) begin
            rsp_last <= 1'b1;
            state    <= S_IDLE;
          end else begin
            idx <= idx + SEL_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int NUM_BANKS  = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int ACCESS_LAT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_last,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wr_done
);
  localparam int SEL_W = $clog2(NUM_BANKS);
  localparam int ROW_W = ADDR_W - SEL_W;

  logic [NUM_BANKS-1:0]             bank_start;
  logic                             bank_we;
  logic [ROW_W-1:0]                 bank_row;
  logic [DATA_W-1:0]                bank_wdata;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic [NUM_BANKS-1:0]             bank_ready;

  ilv_seq #(
    .NB(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(ACCESS_LAT)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_data(rsp_data),
    .wr_done(wr_done),
    .bank_start(bank_start), .bank_we(bank_we), .bank_row(bank_row),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ilv_bank #(
        .DATA_W(DATA_W), .ROW_W(ROW_W), .LAT(ACCESS_LAT)
      ) u_bank (
        .clk(clk), .rst(rst),
        .start(bank_start[b]), .wr_en(bank_we), .row(bank_row),
        .wdata(bank_wdata), .rdata(bank_rdata[b]), .ready(bank_ready[b])
      );
    end
  endgenerate
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
  parameter int NB  = 4,
  parameter int LAT = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic          rsp_valid,
  input logic          rsp_last,
  input logic          wr_done,
  input logic [NB-1:0] bank_ready
);
  localparam int WR_AT = LAT + 1;
  localparam int FIRST = LAT + 2;
  localparam int FINAL = FIRST + NB - 1;
  localparam int CW    = $clog2(FINAL + 2) + 1;

  logic [CW-1:0] since;
  logic [1:0]    op_q;
  logic          armed;
  logic          acc;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      op_q  <= 2'b00;
      armed <= 1'b0;
    end else if (acc) begin
      since <= '0;
      op_q  <= req_op;
      armed <= 1'b1;
    end else if (since < CW'(FINAL + 1)) begin
      since <= since + CW'(1);
    end
  end

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    acc |=> !req_ready);

  assert_idle_banks_R8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> &bank_ready);

  assert_write_time_R7: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> (armed && op_q[1] && since == CW'(WR_AT)));

  assert_rsp_window_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (armed && !op_q[1] && since >= CW'(FIRST) && since <= CW'(FINAL)));

  assert_last_place_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> (rsp_valid &&
                  since == ((op_q == 2'b00) ? CW'(FINAL) : CW'(FIRST))));

  assert_single_last_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && op_q == 2'b01) |-> rsp_last);
endmodule

bind ilv_mem_ctrl ilv_mem_chk #(.NB(NUM_BANKS), .LAT(ACCESS_LAT)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .rsp_last(rsp_last),
  .wr_done(wr_done), .bank_ready(bank_ready)
);

// File: tb/tb_ilv_mem_ctrl.sv
module tb_ilv_mem_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_last, wr_done;
  logic [31:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [256];

  always #4 clk = ~clk;

  ilv_mem_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_data(rsp_data),
    .wr_done(wr_done)
  );

  // {op, addr, data}: data is write data or expected read data
  localparam int NV = 13;
  localparam logic [41:0] VEC [NV] = '{
    {2'b10, 8'd0,  32'h1111_0000}, {2'b10, 8'd1,  32'h2222_0001},
    {2'b10, 8'd2,  32'h3333_0002}, {2'b10, 8'd3,  32'h4444_0003},
    {2'b10, 8'd4,  32'h5555_0004}, {2'b10, 8'd5,  32'h6666_0005},
    {2'b10, 8'd6,  32'h7777_0006}, {2'b10, 8'd7,  32'h8888_0007},
    {2'b01, 8'd2,  32'h3333_0002}, {2'b01, 8'd5,  32'h6666_0005},
    {2'b01, 8'd7,  32'h8888_0007}, {2'b11, 8'd13, 32'hDDDD_000D},
    {2'b01, 8'd13, 32'hDDDD_000D}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive at a falling edge while ready; returns half a cycle after accept
  task automatic send(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d);
    req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d);
    send(op, a, d);
    chk(req_ready == 1'b0, "R8 busy after write accept", {31'd0, req_ready}, 32'd0);
    skip(6);
    chk(wr_done == 1'b0, "R7 no early done", {31'd0, wr_done}, 32'd0);
    skip(1);
    chk(wr_done == 1'b1, "R7 done at access end", {31'd0, wr_done}, 32'd1);
    chk(req_ready == 1'b1, "R9 ready with done", {31'd0, req_ready}, 32'd1);
    model[a] = d;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [31:0] exp);
    send(2'b01, a, 32'd0);
    skip(7);
    chk(rsp_valid == 1'b0, "R6 no early word", {31'd0, rsp_valid}, 32'd0);
    skip(1);
    chk(rsp_valid && rsp_last, "R6 valid+last", {30'd0, rsp_valid, rsp_last}, 32'd3);
    chk(rsp_data == exp, "R2 R6 read data", rsp_data, exp);
  endtask

  task automatic do_block(input logic [7:0] a);
    send(2'b00, a, 32'd0);
    skip(7);
    chk(rsp_valid == 1'b0, "R3 no early word", {31'd0, rsp_valid}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      skip(1);
      chk(rsp_valid == 1'b1, "R3 word valid", {31'd0, rsp_valid}, 32'd1);
      chk(rsp_last == (k == 3), "R4 last flag", {31'd0, rsp_last}, {31'd0, k == 3});
      chk(rsp_data == model[{a[7:2], 2'(k)}], "R2 R4 R5 block word", rsp_data,
          model[{a[7:2], 2'(k)}]);
      if (k == 2) chk(req_ready == 1'b0, "R8 busy mid-block", {31'd0, req_ready}, 32'd0);
      if (k == 3) chk(req_ready == 1'b1, "R9 ready with last", {31'd0, req_ready}, 32'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    skip(3);
    rst = 1'b0;
    skip(1);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk(!rsp_valid && !wr_done, "R1 quiet after reset", {30'd0, rsp_valid, wr_done}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) do_write(VEC[i][41:40], VEC[i][39:32], VEC[i][31:0]);
      else            do_read(VEC[i][39:32], VEC[i][31:0]);
    end

    do_block(8'd0);   // R3 R4
    do_block(8'd4);   // R2
    do_block(8'd6);   // R5 unaligned address
    do_block(8'd7);   // R5

    // R7 write touches one word only
    do_write(2'b10, 8'd5, 32'hCAFE_0005);
    do_block(8'd4);

    // R8 request during busy is dropped
    send(2'b00, 8'd0, 32'd0);
    skip(1);
    req_op = 2'b10; req_addr = 8'd1; req_wdata = 32'hDEAD_BEEF; req_valid = 1'b1;
    skip(1);
    req_valid = 1'b0;
    skip(5);
    chk(wr_done == 1'b0, "R8 busy write ignored", {31'd0, wr_done}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      skip(1);
      chk(rsp_data == model[k], "R8 block during drop", rsp_data, model[k]);
    end
    skip(2);
    chk(rsp_valid == 1'b0, "R8 no extra response", {31'd0, rsp_valid}, 32'd0);
    do_read(8'd1, model[1]);

    // R9 back-to-back blocks
    do_block(8'd0);
    do_block(8'd4);

    // R1 reset in mid-transfer
    send(2'b00, 8'd0, 32'd0);
    skip(3);
    rst = 1'b1;
    skip(2);
    rst = 1'b0;
    skip(1);
    chk(req_ready == 1'b1, "R1 ready after mid reset", {31'd0, req_ready}, 32'd1);
    for (int k = 0; k < 10; k++) begin
      skip(1);
      chk(!rsp_valid && !wr_done, "R1 no response after reset",
          {30'd0, rsp_valid, wr_done}, 32'd0);
    end
    do_read(8'd6, model[6]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule